// File: doc/BRIEF.md
# System-Controller Control and Status Register

This block is a small memory-mapped register for a board that can act as the system controller on a shared backplane. It reports whether the board has been strapped as controller, lets software start a backplane-wide reset, holds a board-fail flag that can pull the backplane fail line and lights a fail LED, and selects the arbitration mode used by the neighbouring bus arbiter.

Software writes the register through a one-cycle write strobe and reads it combinationally. A write of 1 to the reset-request bit starts a sequence that drives the active-low backplane reset for at least a programmable number of clock cycles. The sequence ends, and the bit clears, once that minimum is met and the reset-completion input is high. The fail line is also gated by a global inhibit input that comes from another register. A reset driven onto the backplane by another source forces every control bit to its reset-class default.

Top module: `sysctl_reg`

## Requirements
- R1: Bit 0 reads the level of `jumper_i` (1 = strap pins shorted, board is controller); writes to bit 0 have no effect.
- R2: A write with bit 1 = 1 sets bit 1, and `sysreset_no` is low from the next cycle on; a write with bit 1 = 0 has no effect on the sequence.
- R3: Once started, `sysreset_no` stays low for at least HOLD_CYCLES+1 cycles. Bit 1 clears and `sysreset_no` rises at the first clock edge where the hold count has been reached and `reset_done_i` is high. A `reset_done_i` that arrives earlier is ignored.
- R4: Bit 2 (board fail) is read/write, and `sysfail_no` is low exactly when bit 2 = 1 and `fail_inhibit_i` = 0.
- R5: `fail_led_o` is high when bit 2 = 1 or `wdog_timeout_i` = 1.
- R6: Bit 3 is read/write and drives `arb_rr_o` (1 = round-robin, 0 = priority).
- R7: While `rst_ni` is low, bit 1 = 0, bit 2 = 1 and bit 3 = 0.
- R8: When `ext_sysreset_ni` is low at a clock edge, bit 1 is cleared (releasing `sysreset_no`), bit 2 is set and bit 3 is cleared. This takes priority over a write in the same cycle.
- R9: Bits DATA_W-1 down to 4 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | One-cycle register write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Register read value |
| jumper_i | input | 1 | Controller strap, 1 when shorted |
| fail_inhibit_i | input | 1 | Global fail inhibit, 1 blocks the fail line |
| wdog_timeout_i | input | 1 | Watchdog timeout, lights the LED |
| reset_done_i | input | 1 | Reset-completion indication |
| ext_sysreset_ni | input | 1 | Backplane reset from another source, active low |
| sysreset_no | output | 1 | Backplane reset drive, active low |
| sysfail_no | output | 1 | Backplane fail drive, active low |
| fail_led_o | output | 1 | Fail LED |
| arb_rr_o | output | 1 | Arbitration mode, 1 = round-robin |

## Verification
The assertions check four things on every cycle: the strap read-back, the fail-line and LED gating, the zero upper bits, and the forced defaults after a backplane reset. A counter in the checker also confirms that each release of the reset line happens after the minimum hold and with completion high. Only the bench scenarios can show the rest: a late versus an early completion, a write of 0 that must not start a sequence, a backplane reset that aborts a running sequence while a write arrives, and a reset in the middle of operation.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned BIT_CTRL  = 0;
  localparam int unsigned BIT_SWRST = 1;
  localparam int unsigned BIT_FAIL  = 2;
  localparam int unsigned BIT_ARB   = 3;
  localparam int unsigned USED_BITS = 4;
endpackage

// File: rtl/sysctl_rst_seq.sv
module sysctl_rst_seq #(
  parameter int unsigned HOLD_CYCLES = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_i,
  input  logic start_i,
  input  logic done_i,
  output logic active_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_MAX = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             hold_met;

  assign hold_met = (cnt_q == HOLD_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (ext_rst_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (hold_met && done_i) active_q <= 1'b0;
      else if (!hold_met)     cnt_q    <= cnt_q + 1'b1;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/sysctl_fail_path.sv
module sysctl_fail_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_i,
  input  logic wr_i,
  input  logic wr_val_i,
  input  logic inhibit_i,
  input  logic wdog_i,
  output logic fail_o,
  output logic sysfail_no,
  output logic led_o
);
  logic fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fail_q <= 1'b1;
    else if (ext_rst_i) fail_q <= 1'b1;
    else if (wr_i)      fail_q <= wr_val_i;
  end

  assign fail_o     = fail_q;
  assign sysfail_no = ~(fail_q & ~inhibit_i);
  assign led_o      = fail_q | wdog_i;
endmodule

// File: rtl/sysctl_reg.sv
module sysctl_reg
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned HOLD_CYCLES = 25_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              jumper_i,
  input  logic              fail_inhibit_i,
  input  logic              wdog_timeout_i,
  input  logic              reset_done_i,
  input  logic              ext_sysreset_ni,
  output logic              sysreset_no,
  output logic              sysfail_no,
  output logic              fail_led_o,
  output logic              arb_rr_o
);
  logic ext_rst;
  logic swrst;
  logic fail;
  logic arb_q;

  assign ext_rst = ~ext_sysreset_ni;

  sysctl_rst_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_rst_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_rst_i(ext_rst),
    .start_i  (wr_en_i & wr_data_i[BIT_SWRST]),
    .done_i   (reset_done_i),
    .active_o (swrst)
  );

  sysctl_fail_path u_fail (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_rst_i (ext_rst),
    .wr_i      (wr_en_i),
    .wr_val_i  (wr_data_i[BIT_FAIL]),
    .inhibit_i (fail_inhibit_i),
    .wdog_i    (wdog_timeout_i),
    .fail_o    (fail),
    .sysfail_no(sysfail_no),
    .led_o     (fail_led_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      arb_q <= 1'b0;
    else if (ext_rst) arb_q <= 1'b0;
    else if (wr_en_i) arb_q <= wr_data_i[BIT_ARB];
  end

  always_comb begin
    rd_data_o            = '0;
    rd_data_o[BIT_CTRL]  = jumper_i;
    rd_data_o[BIT_SWRST] = swrst;
    rd_data_o[BIT_FAIL]  = fail;
    rd_data_o[BIT_ARB]   = arb_q;
  end

  assign sysreset_no = ~swrst;
  assign arb_rr_o    = arb_q;
endmodule

// File: rtl/sysctl_reg_chk.sv
module sysctl_reg_chk #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              jumper_i,
  input logic              fail_inhibit_i,
  input logic              wdog_timeout_i,
  input logic              reset_done_i,
  input logic              ext_sysreset_ni,
  input logic              sysreset_no,
  input logic              sysfail_no,
  input logic              fail_led_o,
  input logic              arb_rr_o
);
  int unsigned low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           low_cnt <= 0;
    else if (!sysreset_no) low_cnt <= low_cnt + 1;
    else                   low_cnt <= 0;
  end

  p_ctrl_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[0] == jumper_i);

  p_swrst_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[1] == !sysreset_no);

  p_min_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sysreset_no) && $past(ext_sysreset_ni)) |-> (low_cnt >= HOLD_CYCLES + 1));

  p_release_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sysreset_no) && $past(ext_sysreset_ni)) |-> $past(reset_done_i));

  p_sysfail_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sysfail_no == (rd_data_o[2] && !fail_inhibit_i));

  p_led_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_led_o == (rd_data_o[2] || wdog_timeout_i));

  p_arb_out_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_rr_o == rd_data_o[3]);

  p_ext_defaults_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_sysreset_ni |=> (rd_data_o[2] && !rd_data_o[3] && sysreset_no));

  p_upper_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:4] == '0);
endmodule

bind sysctl_reg sysctl_reg_chk #(.DATA_W(DATA_W), .HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rd_data_o      (rd_data_o),
  .jumper_i       (jumper_i),
  .fail_inhibit_i (fail_inhibit_i),
  .wdog_timeout_i (wdog_timeout_i),
  .reset_done_i   (reset_done_i),
  .ext_sysreset_ni(ext_sysreset_ni),
  .sysreset_no    (sysreset_no),
  .sysfail_no     (sysfail_no),
  .fail_led_o     (fail_led_o),
  .arb_rr_o       (arb_rr_o)
);

// File: tb/sysctl_reg_test.sv
module sysctl_reg_test;
  localparam int DW   = 8;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic jumper = 1'b0, inhibit = 1'b0, wdog = 1'b0, done = 1'b0, ext_n = 1'b1;
  logic [DW-1:0] rd;
  logic sysreset_n, sysfail_n, led, arb;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit m_swrst, m_fail, m_arb;
  int m_cnt;

  always #4 clk = ~clk;

  sysctl_reg #(.DATA_W(DW), .HOLD_CYCLES(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd), .jumper_i(jumper), .fail_inhibit_i(inhibit),
    .wdog_timeout_i(wdog), .reset_done_i(done), .ext_sysreset_ni(ext_n),
    .sysreset_no(sysreset_n), .sysfail_no(sysfail_n), .fail_led_o(led),
    .arb_rr_o(arb)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_swrst <= 0; m_cnt <= 0; m_fail <= 1; m_arb <= 0;
    end else if (!ext_n) begin
      m_swrst <= 0; m_cnt <= 0; m_fail <= 1; m_arb <= 0;
    end else begin
      if (m_swrst) begin
        if (m_cnt >= HOLD && done) m_swrst <= 0;
        else if (m_cnt < HOLD) m_cnt <= m_cnt + 1;
      end else if (wr_en && wr_data[1]) begin
        m_swrst <= 1; m_cnt <= 0;
      end
      if (wr_en) begin
        m_fail <= wr_data[2]; m_arb <= wr_data[3];
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    cyc++;
    chk("R1 ctrl flag", int'(rd[0]), int'(jumper));
    chk("R2 swrst bit", int'(rd[1]), int'(m_swrst));
    chk("R3 sysreset_no", int'(sysreset_n), int'(!m_swrst));
    chk("R4 fail bit", int'(rd[2]), int'(m_fail));
    chk("R4 sysfail_no", int'(sysfail_n), int'(!(m_fail && !inhibit)));
    chk("R5 fail led", int'(led), int'(m_fail || wdog));
    chk("R6 arb bit", int'(rd[3]), int'(m_arb));
    chk("R6 arb_rr_o", int'(arb), int'(m_arb));
    chk("R9 upper bits", int'(rd[DW-1:4]), 0);
    if (cyc > 20000) begin
      chk("watchdog", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk); #1;
      wr_en = 0;
    end
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge clk); #1;
    wr_en = 1; wr_data = d;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  initial begin
    idle(3);
    chk("R7 swrst in reset", int'(rd[1]), 0);
    chk("R7 fail in reset", int'(rd[2]), 1);
    chk("R7 arb in reset", int'(rd[3]), 0);
    rst_n = 1;
    idle(2);
    jumper = 1; idle(2);
    chk("R1 jumper shorted", int'(rd[0]), 1);
    wr(8'h00);
    chk("R1 write ignored", int'(rd[0]), 1);
    chk("R2 write 0 no start", int'(sysreset_n), 1);
    chk("R4 fail cleared", int'(sysfail_n), 1);
    wr(8'hF4);
    chk("R9 upper writes ignored", int'(rd[DW-1:4]), 0);
    chk("R4 fail drives line", int'(sysfail_n), 0);
    inhibit = 1; idle(1);
    chk("R4 inhibit releases line", int'(sysfail_n), 1);
    wr(8'h08);
    chk("R5 led off", int'(led), 0);
    chk("R6 round-robin", int'(arb), 1);
    wdog = 1; idle(1);
    chk("R5 watchdog led", int'(led), 1);
    wdog = 0; inhibit = 0;
    // software reset, completion held high early
    done = 1;
    wr(8'h0A);
    chk("R2 sequence started", int'(sysreset_n), 0);
    idle(HOLD - 3);
    chk("R3 early done ignored", int'(sysreset_n), 0);
    idle(6);
    chk("R3 released", int'(sysreset_n), 1);
    // completion late
    done = 0;
    wr(8'h02);
    idle(HOLD + 8);
    chk("R3 waits for done", int'(sysreset_n), 0);
    done = 1; idle(2);
    chk("R3 released on done", int'(rd[1]), 0);
    done = 0;
    // backplane reset aborts sequence, beats a write
    wr(8'h0A);
    idle(4);
    @(negedge clk); #1;
    ext_n = 0; wr_en = 1; wr_data = 8'h08;
    @(negedge clk); #1;
    ext_n = 1; wr_en = 0;
    chk("R8 sequence aborted", int'(sysreset_n), 1);
    chk("R8 fail set", int'(rd[2]), 1);
    chk("R8 arb cleared", int'(rd[3]), 0);
    idle(3);
    // mid-run reset
    wr(8'h0A);
    idle(2);
    rst_n = 0; idle(1);
    chk("R7 async swrst", int'(sysreset_n), 1);
    chk("R7 async fail", int'(rd[2]), 1);
    chk("R7 async arb", int'(arb), 0);
    rst_n = 1; jumper = 0;
    idle(3);
    chk("R1 jumper open", int'(rd[0]), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule